// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block sits beside a hart's trap logic and decides which local interrupt, if any, the hart should take next. It holds the pending-interrupt vector and combines it with an enable vector, a delegation mask, the current privilege level and the machine and supervisor global enable bits. Interrupts that are not delegated obey the machine-level enable rule. Delegated ones obey the supervisor-level rule. Among the interrupts that qualify, the lowest-numbered one wins. The choice is registered and presented as an index plus a valid flag.

Pending bits are changed by a masked update. Only the bits selected by the mask take the new value, and the pre-update vector is returned in the same cycle. An interrupt request line follows the pending vector's transitions between all-zero and non-zero. A claim register lets external interrupt controllers take exclusive hardware ownership of pending bits. A claim is refused when it overlaps bits that are already owned, and a refused claim leaves the register untouched.

All pins are plain control and status signals. The update and claim ports are single-cycle strobes with no back-pressure: the block accepts every strobe in the cycle it is presented.

Top module: `irq_select_top`

## Requirements
- R1: After active-low reset the pending vector, the claim register, the request line and the selection valid flag are all zero.
- R2: When `upd_en` is high at a clock edge, each pending bit whose `upd_mask` bit is 1 takes the matching `upd_value` bit, and every other pending bit keeps its value. During that same cycle `upd_old` shows the pending vector as it was before the edge.
- R3: `irq_req` becomes 1 on the edge where the pending vector changes from zero to non-zero. It becomes 0 on the edge where the pending vector changes from non-zero to zero. Otherwise it holds.
- R4: While `clm_req` is high, `clm_fail` is 1 in the same cycle if any bit of `clm_bits` is already set in `owned`. A refused claim leaves `owned` unchanged. An accepted claim ORs `clm_bits` into `owned` at the edge.
- R5: A non-delegated interrupt (its `deleg` bit is 0) qualifies when `priv` is below 3. It also qualifies when `priv` is 3 (machine) and `mie_g` is 1. Privilege is encoded as 0 user, 1 supervisor, 3 machine.
- R6: A delegated interrupt (its `deleg` bit is 1) qualifies when `priv` is 0 (user). It also qualifies when `priv` is 1 (supervisor) and `sie_g` is 1. It never qualifies in machine mode.
- R7: When several interrupts qualify, `sel_idx` is the lowest qualifying bit index. When none qualify, `sel_valid` is 0 and `sel_idx` is 0.
- R8: Only bits set in both the pending vector and `enable` are candidates. The selection is registered: `sel_valid` and `sel_idx` reflect the pending vector and control inputs present before the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Masked pending update strobe |
| upd_mask | input | NIRQ | Bits to replace |
| upd_value | input | NIRQ | New values for the masked bits |
| upd_old | output | NIRQ | Pending vector before the update |
| clm_req | input | 1 | Claim request strobe |
| clm_bits | input | NIRQ | Bits requested for ownership |
| clm_fail | output | 1 | Claim overlaps owned bits (refused) |
| owned | output | NIRQ | Claim register |
| pend | output | NIRQ | Current pending vector |
| irq_req | output | 1 | Interrupt request line |
| enable | input | NIRQ | Per-interrupt enable |
| deleg | input | NIRQ | Per-interrupt delegation to supervisor |
| priv | input | 2 | Current privilege level |
| mie_g | input | 1 | Machine global interrupt enable |
| sie_g | input | 1 | Supervisor global interrupt enable |
| sel_valid | output | 1 | An interrupt is selected |
| sel_idx | output | IDXW | Index of the selected interrupt |

## Verification
A masked pending update and a claim request can land on the same edge. The pending update also changes what the selector sees one cycle later. The bench strobes `upd_en` and `clm_req` together, once with a claim that overlaps owned bits and once with a claim that does not. It checks that the pending vector, `upd_old`, `owned` and `clm_fail` each match the values they would have if each strobe had been applied alone. The bench also clears the last pending bit while the selection is valid. It checks that the request line drops on the first edge and that `sel_valid` drops on the second.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [NIRQ-1:0] upd_mask,
  input  logic [NIRQ-1:0] upd_value,
  output logic [NIRQ-1:0] pend_q,
  output logic            irq_q
);
  logic [NIRQ-1:0] pend_nx;
  logic            was_idle, now_idle;

  assign pend_nx  = (pend_q & ~upd_mask) | (upd_value & upd_mask);
  assign was_idle = (pend_q == '0);
  assign now_idle = (pend_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_nx;
      if (was_idle && !now_idle)      irq_q <= 1'b1;
      else if (!was_idle && now_idle) irq_q <= 1'b0;
    end
  end

  // R2
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> ((pend_q & ~$past(upd_mask)) == ($past(pend_q) & ~$past(upd_mask))));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(pend_q));
  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (pend_q != '0));
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clm_req,
  input  logic [NIRQ-1:0] clm_bits,
  output logic            clm_fail,
  output logic [NIRQ-1:0] owned_q
);
  assign clm_fail = clm_req && ((owned_q & clm_bits) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                   owned_q <= '0;
    else if (clm_req && !clm_fail) owned_q <= owned_q | clm_bits;
  end

  // R4
  refused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clm_fail |=> $stable(owned_q));
  // R4
  owned_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clm_req |=> ((owned_q & $past(owned_q)) == $past(owned_q)));
  // R4
  no_req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clm_req |=> $stable(owned_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_sel_pkg::*;
#(
  parameter int NIRQ = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] enable,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            mie_g,
  input  logic            sie_g,
  output logic            sel_valid,
  output logic [IDXW-1:0] sel_idx
);
  logic            m_open, s_open;
  logic [NIRQ-1:0] live, cand;
  logic            win_v;
  logic [IDXW-1:0] win_i;

  assign m_open = (priv < PRIV_MACH)  || ((priv == PRIV_MACH)  && mie_g);
  assign s_open = (priv < PRIV_SUPER) || ((priv == PRIV_SUPER) && sie_g);
  assign live   = pend & enable;
  assign cand   = (live & ~deleg & {NIRQ{m_open}}) | (live & deleg & {NIRQ{s_open}});

  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_v = 1'b1;
        win_i = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else begin
      sel_valid <= win_v;
      sel_idx   <= win_i;
    end
  end

  // R7
  idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_idx == '0));
  // R8
  valid_follows_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == $past(cand != '0));
  // R8
  live_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $past(live != '0));
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top #(
  parameter  int NIRQ = 32,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [NIRQ-1:0] upd_mask,
  input  logic [NIRQ-1:0] upd_value,
  output logic [NIRQ-1:0] upd_old,
  input  logic            clm_req,
  input  logic [NIRQ-1:0] clm_bits,
  output logic            clm_fail,
  output logic [NIRQ-1:0] owned,
  output logic [NIRQ-1:0] pend,
  output logic            irq_req,
  input  logic [NIRQ-1:0] enable,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            mie_g,
  input  logic            sie_g,
  output logic            sel_valid,
  output logic [IDXW-1:0] sel_idx
);
  logic [NIRQ-1:0] pend_q;

  irq_pend_reg #(.NIRQ(NIRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
    .upd_value(upd_value), .pend_q(pend_q), .irq_q(irq_req)
  );

  irq_claim_reg #(.NIRQ(NIRQ)) u_claim (
    .clk(clk), .rst_n(rst_n), .clm_req(clm_req), .clm_bits(clm_bits),
    .clm_fail(clm_fail), .owned_q(owned)
  );

  irq_pick #(.NIRQ(NIRQ), .IDXW(IDXW)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .enable(enable), .deleg(deleg),
    .priv(priv), .mie_g(mie_g), .sie_g(sie_g),
    .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  assign pend    = pend_q;
  assign upd_old = pend_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && owned == '0 && !irq_req && !sel_valid));
endmodule

// File: tb/test_irq_select_top.sv
module test_irq_select_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [31:0] upd_mask = '0, upd_value = '0, upd_old;
  logic        clm_req = 1'b0;
  logic [31:0] clm_bits = '0, owned, pend;
  logic        clm_fail, irq_req;
  logic [31:0] enable = '0, deleg = '0;
  logic [1:0]  priv = 2'd3;
  logic        mie_g = 1'b0, sie_g = 1'b0;
  logic        sel_valid;
  logic [4:0]  sel_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_select_top #(.NIRQ(32)) i_irq_select_top (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
    .upd_value(upd_value), .upd_old(upd_old), .clm_req(clm_req),
    .clm_bits(clm_bits), .clm_fail(clm_fail), .owned(owned), .pend(pend),
    .irq_req(irq_req), .enable(enable), .deleg(deleg), .priv(priv),
    .mie_g(mie_g), .sie_g(sie_g), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one edge; return at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_upd(logic [31:0] m, logic [31:0] v);
    upd_en = 1'b1; upd_mask = m; upd_value = v;
    step();
    upd_en = 1'b0;
  endtask

  task automatic sel_chk(string req, logic v, logic [4:0] i);
    step();
    chk({req, " valid"}, 32'(sel_valid), 32'(v));
    chk({req, " index"}, 32'(sel_idx), 32'(i));
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 0);
    chk("R1 owned", owned, 0);
    chk("R1 irq", 32'(irq_req), 0);
    chk("R1 sel_valid", 32'(sel_valid), 0);
  endtask

  task automatic t_update();
    upd_en = 1'b1; upd_mask = 32'hFFFF_FFFF; upd_value = 32'hA5A5_0000;
    #1 chk("R2 old before first", upd_old, 0);
    @(negedge clk); upd_en = 1'b0;
    chk("R2 full write", pend, 32'hA5A5_0000);
    upd_en = 1'b1; upd_mask = 32'h0000_FF0F; upd_value = 32'h1234_5678;
    #1 chk("R2 old returned", upd_old, 32'hA5A5_0000);
    @(negedge clk); upd_en = 1'b0;
    chk("R2 masked write", pend, 32'hA5A5_5608);
    do_upd(32'hFFFF_FFFF, 0);
  endtask

  task automatic t_irq();
    chk("R3 idle", 32'(irq_req), 0);
    do_upd(32'h0000_0010, 32'h0000_0010);
    chk("R3 rise", 32'(irq_req), 1);
    do_upd(32'h0000_0100, 32'h0000_0100);
    chk("R3 hold nonzero", 32'(irq_req), 1);
    do_upd(32'h0000_0010, 0);
    chk("R3 still nonzero", 32'(irq_req), 1);
    do_upd(32'hFFFF_FFFF, 0);
    chk("R3 fall", 32'(irq_req), 0);
  endtask

  task automatic t_claim();
    clm_req = 1'b1; clm_bits = 32'h3;
    #1 chk("R4 first ok", 32'(clm_fail), 0);
    @(negedge clk);
    chk("R4 first owned", owned, 32'h3);
    clm_bits = 32'h6;
    #1 chk("R4 overlap fail", 32'(clm_fail), 1);
    @(negedge clk);
    chk("R4 refused unchanged", owned, 32'h3);
    clm_bits = 32'h8;
    #1 chk("R4 disjoint ok", 32'(clm_fail), 0);
    @(negedge clk); clm_req = 1'b0;
    chk("R4 grown", owned, 32'hB);
  endtask

  task automatic t_gate();
    enable = '1; deleg = '0; priv = 2'd3; mie_g = 0; sie_g = 0;
    do_upd('1, 32'h0000_0020);
    sel_chk("R5 machine mie off", 0, 0);
    mie_g = 1;
    sel_chk("R5 machine mie on", 1, 5);
    mie_g = 0; priv = 2'd1;
    sel_chk("R5 supervisor below machine", 1, 5);
    priv = 2'd0;
    sel_chk("R5 user below machine", 1, 5);
    deleg = 32'h0000_0020; priv = 2'd3; mie_g = 1; sie_g = 1;
    sel_chk("R6 delegated in machine", 0, 0);
    priv = 2'd1; sie_g = 0;
    sel_chk("R6 supervisor sie off", 0, 0);
    sie_g = 1;
    sel_chk("R6 supervisor sie on", 1, 5);
    sie_g = 0; priv = 2'd0;
    sel_chk("R6 user", 1, 5);
    deleg = '0; priv = 2'd3; mie_g = 1;
    do_upd('1, 0);
    step();
  endtask

  task automatic t_prio();
    enable = '1; deleg = '0; priv = 2'd3; mie_g = 1;
    do_upd('1, 32'h0010_0088);
    sel_chk("R7 lowest of three", 1, 3);
    enable = 32'hFFFF_FFF7;
    #1 chk("R8 registered hold", 32'(sel_idx), 3);
    sel_chk("R8 enable masks bit3", 1, 7);
    deleg = 32'h0000_0080;
    sel_chk("R7 blocked delegated skipped", 1, 20);
    deleg = '0; enable = '1;
    do_upd('1, 32'h8000_0000);
    sel_chk("R7 top bit", 1, 31);
    enable = '0;
    sel_chk("R7 none qualify", 0, 0);
    enable = '1;
    do_upd('1, 0);
    step();
  endtask

  task automatic t_same_cycle();
    enable = '1; priv = 2'd3; mie_g = 1;
    do_upd('1, 32'h0000_0040);
    step();
    upd_en = 1; upd_mask = 32'h0000_0040; upd_value = 0;
    clm_req = 1; clm_bits = 32'h2;
    #1 chk("R4 same-cycle overlap fail", 32'(clm_fail), 1);
    chk("R2 same-cycle old", upd_old, 32'h40);
    @(negedge clk); upd_en = 0; clm_req = 0;
    chk("R2 same-cycle pend", pend, 0);
    chk("R4 same-cycle owned", owned, 32'hB);
    chk("R3 same-cycle fall", 32'(irq_req), 0);
    chk("R8 sel lags one edge", 32'(sel_valid), 1);
    step();
    chk("R8 sel drops", 32'(sel_valid), 0);
    upd_en = 1; upd_mask = 32'h1; upd_value = 32'h1;
    clm_req = 1; clm_bits = 32'h10;
    #1 chk("R4 same-cycle ok", 32'(clm_fail), 0);
    @(negedge clk); upd_en = 0; clm_req = 0;
    chk("R4 same-cycle grown", owned, 32'h1B);
    chk("R2 same-cycle set", pend, 32'h1);
    chk("R3 same-cycle rise", 32'(irq_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update();
    t_irq();
    t_claim();
    t_gate();
    t_prio();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule